// File: doc/BRIEF.md
# Secured OTP Region Controller

This block guards a 64-byte one-time-programmable security space that sits beside a serial flash main array. Upstream command decoding hands it single-cycle strobes (enter the OTP mode, leave it, write the security register) together with read-start, read-continue and program requests that carry a byte address and a data byte. While the OTP mode is active, reads and programs are redirected into the small OTP space and the main array is cut off. Outside that mode, every access is passed on to the main array through a one-cycle go pulse.

The OTP space has two parts. Offsets 0 to 15 hold a factory serial number. It is fixed at build time and can never be programmed. Offsets 16 to 63 belong to the customer and power up erased (all ones). A program can only clear bits. A one-way lock-down bit, set by the security-register write command, freezes the customer part for good. The lock bit and the customer bytes model non-volatile cells, so they keep their values through the synchronous reset. Only one access strobe is honoured per cycle, with the priority: lock command, then program, then read-start, then read-continue.

Top module: `otp_guard`

## Requirements
- R1: `otp_mode_o` is 0 after reset. An enter strobe sets it and an exit strobe clears it, visible one cycle later. When both strobes arrive in the same cycle, exit wins.
- R2: While `otp_mode_o` is 1, no request produces `main_go_o`. While it is 0, each read-start, read-continue or program request produces `main_go_o` and `grant_o` one cycle later.
- R3: In OTP mode, a read-start uses only address bits [5:0] as the offset, and `rdata_o` shows that byte one cycle later. Each read-continue shows the next offset, and offset 63 is followed by offset 0.
- R4: Offset k in 0..15 reads as byte (k mod 4) of `ESN_SEED` (byte 0 = bits 7:0) XOR (k*29 mod 256). A program to these offsets gets `reject_o` and changes nothing.
- R5: Offsets 16..63 read 8'hFF after power-up. An accepted program stores old AND new and gets `grant_o`. A read issued in the cycle after the program sees the new value.
- R6: A security-register write with `lock_aligned_i`=1 sets the lock bit (`secreg_o[1]`) and gets `grant_o`. With `lock_aligned_i`=0 it gets `reject_o` and the lock bit is unchanged.
- R7: Once the lock bit is 1, programs to offsets 16..63 get `reject_o` and leave the byte unchanged. The lock bit never returns to 0.
- R8: Reset clears the mode, the read pointer, `rdata_o` and the result pulses. The lock bit and the customer bytes keep their values through reset.
- R9: `secreg_o[0]` (factory lock) always reads 1 and `secreg_o[7:2]` always read 0.
- R10: `grant_o`, `reject_o` and `main_go_o` are single-cycle results of the request one cycle earlier. `grant_o` and `reject_o` are never both 1. Mode strobes and idle cycles produce none of the three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_enter_i | input | 1 | Strobe: enter OTP mode |
| cmd_exit_i | input | 1 | Strobe: leave OTP mode |
| cmd_lock_i | input | 1 | Strobe: security-register write (lock-down) |
| lock_aligned_i | input | 1 | Chip select rose on a byte boundary for the lock command |
| rd_start_i | input | 1 | Start a read at `addr_i` |
| rd_next_i | input | 1 | Continue a read at the next offset |
| wr_req_i | input | 1 | Program request at `addr_i` with `wdata_i` |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 8 | Program data |
| otp_mode_o | output | 1 | OTP mode active |
| grant_o | output | 1 | Previous request accepted |
| reject_o | output | 1 | Previous request refused |
| main_go_o | output | 1 | Previous request forwarded to the main array |
| rdata_o | output | 8 | Last OTP byte read |
| secreg_o | output | 8 | Security register: bit 0 factory lock, bit 1 customer lock |

## Verification
Every registered result is due one rising edge after the strobe that causes it: mode, lock bit, result pulses and `rdata_o`. A byte changed by a program is due two edges after the program request, because the read must be issued in the following cycle. The bench keeps a behavioural model that updates on the same rising edge as the design and compares all outputs on the falling edge that follows. The comparison therefore always looks at the value due for that edge and never at one still in flight. Directed sequences cover the priority of exit over enter, the read wrap past the last offset, the alignment rule for the lock, and retention of the lock and programmed bytes through a mid-run reset.

// File: rtl/otp_pkg.sv
// Shared constants, types and the factory serial-number generator for the
// secured OTP controller. Assumes byte-wide data throughout.
package otp_pkg;

    localparam int BYTE_W          = 8;
    localparam int SEC_FACTORY_BIT = 0;
    localparam int SEC_LOCK_BIT    = 1;

    // Access chosen for a cycle after priority resolution.
    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_LOCK,
        ACC_WRITE,
        ACC_RSTART,
        ACC_RNEXT
    } acc_kind_e;

    // Factory serial byte: a seed lane mixed with a scaled index.
    function automatic logic [BYTE_W-1:0] esn_byte(input logic [31:0] seed,
                                                  input int unsigned idx);
        logic [BYTE_W-1:0] lane;
        lane = seed[8*(idx%4) +: 8];
        return lane ^ BYTE_W'(idx * 29);
    endfunction

endpackage

// File: rtl/otp_store.sv
// Storage for the OTP space. Offsets below ESN_BYTES are computed constants
// (factory region). The remaining bytes are customer cells that power up
// erased and only ever lose bits. The cells model non-volatile memory, so
// they have no reset. Assumes wr_en_i is already qualified by the caller.
module otp_store
    import otp_pkg::*;
#(
    parameter int          OFF_W     = 6,
    parameter int          OTP_BYTES = 64,
    parameter int          ESN_BYTES = 16,
    parameter logic [31:0] ESN_SEED  = 32'hC3A5_5A17
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [OFF_W-1:0]  wr_off_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic [OFF_W-1:0]  rd_off_i,
    output logic [BYTE_W-1:0] rd_byte_o
);

    localparam int CUST_BYTES = OTP_BYTES - ESN_BYTES;
    localparam int CIDX_W     = (CUST_BYTES > 1) ? $clog2(CUST_BYTES) : 1;
    localparam logic [OFF_W-1:0] ESN_END = OFF_W'(ESN_BYTES);

    logic [BYTE_W-1:0] cust_view [CUST_BYTES];

    for (genvar i = 0; i < CUST_BYTES; i++) begin : g_cell
        logic [BYTE_W-1:0] cell_q = {BYTE_W{1'b1}};

        // Program-only cell: bits can be cleared, never set.
        always_ff @(posedge clk) begin
            if (wr_en_i && (wr_off_i == OFF_W'(ESN_BYTES + i))) begin
                cell_q <= cell_q & wr_data_i;
            end
        end

        assign cust_view[i] = cell_q;
    end

    // Read mux: factory constants below the split, customer cells above.
    always_comb begin
        if (rd_off_i < ESN_END) begin
            rd_byte_o = esn_byte(ESN_SEED, 32'(rd_off_i));
        end else begin
            rd_byte_o = cust_view[CIDX_W'(rd_off_i - ESN_END)];
        end
    end

endmodule

// File: rtl/otp_mode_ctl.sv
// Mode and lock state. The mode flag is volatile and cleared by reset. The
// lock-down bit models a non-volatile fuse: it starts at 0 at power-up,
// ignores reset and can only be set. Assumes the alignment flag is valid in
// the same cycle as the lock strobe.
module otp_mode_ctl
    import otp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_enter_i,
    input  logic              cmd_exit_i,
    input  logic              cmd_lock_i,
    input  logic              lock_aligned_i,
    output logic              mode_o,
    output logic              lock_o,
    output logic [BYTE_W-1:0] secreg_o
);

    logic mode_q;
    logic lock_q = 1'b0;

    // Mode flag: exit takes priority over enter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else if (cmd_exit_i) begin
            mode_q <= 1'b0;
        end else if (cmd_enter_i) begin
            mode_q <= 1'b1;
        end
    end

    // One-way lock: set only by an aligned lock command outside reset.
    always_ff @(posedge clk) begin
        if (rst_n && cmd_lock_i && lock_aligned_i) begin
            lock_q <= 1'b1;
        end
    end

    // Security register view: factory bit tied high, lock bit from the fuse.
    always_comb begin
        secreg_o                  = '0;
        secreg_o[SEC_FACTORY_BIT] = 1'b1;
        secreg_o[SEC_LOCK_BIT]    = lock_q;
    end

    assign mode_o = mode_q;
    assign lock_o = lock_q;

endmodule

// File: rtl/otp_access.sv
// Access sequencer. It picks one access per cycle (lock, program, read-start,
// read-continue, in that priority), decides grant, reject or forward to the
// main array, and drives the storage write and read offsets. It also holds
// the read pointer and the registered result outputs. Assumes the mode and
// lock inputs are the registered state from before the current edge.
module otp_access
    import otp_pkg::*;
#(
    parameter int OFF_W     = 6,
    parameter int ESN_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              lock_i,
    input  logic              cmd_lock_i,
    input  logic              lock_aligned_i,
    input  logic              rd_start_i,
    input  logic              rd_next_i,
    input  logic              wr_req_i,
    input  logic [OFF_W-1:0]  req_off_i,
    input  logic [BYTE_W-1:0] rd_byte_i,
    output logic [OFF_W-1:0]  rd_off_o,
    output logic              wr_en_o,
    output logic              grant_o,
    output logic              reject_o,
    output logic              main_go_o,
    output logic [BYTE_W-1:0] rdata_o
);

    localparam logic [OFF_W-1:0] ESN_END = OFF_W'(ESN_BYTES);

    acc_kind_e         kind;
    logic              grant_d, reject_d, main_d, rd_hit;
    logic [OFF_W-1:0]  ptr_q;
    logic              grant_q, reject_q, main_q;
    logic [BYTE_W-1:0] rdata_q;

    // Priority pick of the single access served this cycle.
    always_comb begin
        if (cmd_lock_i)      kind = ACC_LOCK;
        else if (wr_req_i)   kind = ACC_WRITE;
        else if (rd_start_i) kind = ACC_RSTART;
        else if (rd_next_i)  kind = ACC_RNEXT;
        else                 kind = ACC_IDLE;
    end

    // Decision: accept, refuse, or hand the access to the main array.
    always_comb begin
        grant_d  = 1'b0;
        reject_d = 1'b0;
        main_d   = 1'b0;
        rd_hit   = 1'b0;
        wr_en_o  = 1'b0;
        unique case (kind)
            ACC_LOCK: begin
                grant_d  = lock_aligned_i;
                reject_d = !lock_aligned_i;
            end
            ACC_WRITE: begin
                if (!mode_i) begin
                    main_d  = 1'b1;
                    grant_d = 1'b1;
                end else if ((req_off_i < ESN_END) || lock_i) begin
                    reject_d = 1'b1;
                end else begin
                    wr_en_o = 1'b1;
                    grant_d = 1'b1;
                end
            end
            ACC_RSTART, ACC_RNEXT: begin
                grant_d = 1'b1;
                main_d  = !mode_i;
                rd_hit  = mode_i;
            end
            default: ;
        endcase
    end

    assign rd_off_o = (kind == ACC_RSTART) ? req_off_i : ptr_q;

    // Result pulses, read data and the wrapping stream pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q  <= 1'b0;
            reject_q <= 1'b0;
            main_q   <= 1'b0;
            rdata_q  <= '0;
            ptr_q    <= '0;
        end else begin
            grant_q  <= grant_d;
            reject_q <= reject_d;
            main_q   <= main_d;
            if (rd_hit) begin
                rdata_q <= rd_byte_i;
                ptr_q   <= rd_off_o + OFF_W'(1);
            end
        end
    end

    assign grant_o   = grant_q;
    assign reject_o  = reject_q;
    assign main_go_o = main_q;
    assign rdata_o   = rdata_q;

endmodule

// File: rtl/otp_guard.sv
// Top of the secured OTP controller. It ties the mode/lock state, the access
// sequencer and the OTP storage together. Only the low address bits that
// span the OTP space are used. Assumes strobes come from an upstream command
// decoder, one command per cycle.
module otp_guard
    import otp_pkg::*;
#(
    parameter int          ADDR_W    = 24,
    parameter int          OTP_BYTES = 64,
    parameter int          ESN_BYTES = 16,
    parameter logic [31:0] ESN_SEED  = 32'hC3A5_5A17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_enter_i,
    input  logic              cmd_exit_i,
    input  logic              cmd_lock_i,
    input  logic              lock_aligned_i,
    input  logic              rd_start_i,
    input  logic              rd_next_i,
    input  logic              wr_req_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    output logic              otp_mode_o,
    output logic              grant_o,
    output logic              reject_o,
    output logic              main_go_o,
    output logic [7:0]        rdata_o,
    output logic [7:0]        secreg_o
);

    localparam int OFF_W = $clog2(OTP_BYTES);

    logic              mode, lock, wr_en;
    logic [OFF_W-1:0]  req_off, rd_off;
    logic [BYTE_W-1:0] rd_byte;
    logic              unused_hi_addr;

    assign req_off        = addr_i[OFF_W-1:0];
    assign unused_hi_addr = ^addr_i[ADDR_W-1:OFF_W];
    assign otp_mode_o     = mode;

    otp_mode_ctl u_mode (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_enter_i    (cmd_enter_i),
        .cmd_exit_i     (cmd_exit_i),
        .cmd_lock_i     (cmd_lock_i),
        .lock_aligned_i (lock_aligned_i),
        .mode_o         (mode),
        .lock_o         (lock),
        .secreg_o       (secreg_o)
    );

    otp_access #(
        .OFF_W     (OFF_W),
        .ESN_BYTES (ESN_BYTES)
    ) u_access (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_i         (mode),
        .lock_i         (lock),
        .cmd_lock_i     (cmd_lock_i),
        .lock_aligned_i (lock_aligned_i),
        .rd_start_i     (rd_start_i),
        .rd_next_i      (rd_next_i),
        .wr_req_i       (wr_req_i),
        .req_off_i      (req_off),
        .rd_byte_i      (rd_byte),
        .rd_off_o       (rd_off),
        .wr_en_o        (wr_en),
        .grant_o        (grant_o),
        .reject_o       (reject_o),
        .main_go_o      (main_go_o),
        .rdata_o        (rdata_o)
    );

    otp_store #(
        .OFF_W     (OFF_W),
        .OTP_BYTES (OTP_BYTES),
        .ESN_BYTES (ESN_BYTES),
        .ESN_SEED  (ESN_SEED)
    ) u_store (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_off_i  (req_off),
        .wr_data_i (wdata_i),
        .rd_off_i  (rd_off),
        .rd_byte_o (rd_byte)
    );

endmodule

// File: rtl/otp_guard_chk.sv
// Port-level protocol checker for otp_guard, attached with bind below.
module otp_guard_chk #(
    parameter int ADDR_W    = 24,
    parameter int OFF_W     = 6,
    parameter int ESN_BYTES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_enter_i,
    input logic              cmd_exit_i,
    input logic              cmd_lock_i,
    input logic              lock_aligned_i,
    input logic              rd_start_i,
    input logic              rd_next_i,
    input logic              wr_req_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [7:0]        wdata_i,
    input logic              otp_mode_o,
    input logic              grant_o,
    input logic              reject_o,
    input logic              main_go_o,
    input logic [7:0]        rdata_o,
    input logic [7:0]        secreg_o
);

    logic factory_hit;
    assign factory_hit = (addr_i[OFF_W-1:0] < OFF_W'(ESN_BYTES));

    p_enter_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_enter_i && !cmd_exit_i) |=> otp_mode_o);

    p_exit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_exit_i |=> !otp_mode_o);

    p_main_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        otp_mode_o |=> !main_go_o);

    p_factory_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (otp_mode_o && wr_req_i && !cmd_lock_i && factory_hit) |=> reject_o);

    p_lock_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_lock_i && lock_aligned_i) |=> (secreg_o[1] && grant_o));

    p_lock_misaligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_lock_i && !lock_aligned_i) |=> reject_o);

    p_locked_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (otp_mode_o && wr_req_i && !cmd_lock_i && secreg_o[1]) |=> reject_o);

    p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        secreg_o[1] |=> secreg_o[1]);

    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_o && reject_o));

    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_lock_i || wr_req_i || rd_start_i || rd_next_i)
        |=> !(grant_o || reject_o || main_go_o));

endmodule

bind otp_guard otp_guard_chk #(
    .ADDR_W    (ADDR_W),
    .OFF_W     (OFF_W),
    .ESN_BYTES (ESN_BYTES)
) u_chk (.*);

// File: tb/otp_guard_tb.sv
// Bench for otp_guard: behavioural reference model updated on each rising
// edge, all outputs compared on the following falling edge.
module otp_guard_tb;

    localparam int          ADDR_W = 24;
    localparam logic [31:0] SEED   = 32'hC3A5_5A17;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              cmd_enter = 0, cmd_exit = 0, cmd_lock = 0, lock_aligned = 0;
    logic              rd_start = 0, rd_next = 0, wr_req = 0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        wdata = '0;
    logic              otp_mode, grant, reject, main_go;
    logic [7:0]        rdata, secreg;

    otp_guard #(
        .ADDR_W    (ADDR_W),
        .OTP_BYTES (64),
        .ESN_BYTES (16),
        .ESN_SEED  (SEED)
    ) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_enter_i    (cmd_enter),
        .cmd_exit_i     (cmd_exit),
        .cmd_lock_i     (cmd_lock),
        .lock_aligned_i (lock_aligned),
        .rd_start_i     (rd_start),
        .rd_next_i      (rd_next),
        .wr_req_i       (wr_req),
        .addr_i         (addr),
        .wdata_i        (wdata),
        .otp_mode_o     (otp_mode),
        .grant_o        (grant),
        .reject_o       (reject),
        .main_go_o      (main_go),
        .rdata_o        (rdata),
        .secreg_o       (secreg)
    );

    int    checks = 0;
    int    errors = 0;
    bit    cmp_on = 0;
    string cur_req = "R3";

    // Reference model state.
    int m_mem [64];
    bit m_mode = 0, m_lock = 0, m_grant = 0, m_reject = 0, m_main = 0;
    int m_ptr = 0, m_rdata = 0;

    initial begin
        for (int k = 0; k < 64; k++) begin
            if (k < 16) m_mem[k] = ((SEED >> (8 * (k % 4))) & 255) ^ ((k * 29) % 256);
            else        m_mem[k] = 255;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Model update on the same edge as the design.
    always @(posedge clk) begin
        bit g, r, mn;
        int off;
        if (!rst_n) begin
            m_mode = 0; m_ptr = 0; m_rdata = 0;
            m_grant = 0; m_reject = 0; m_main = 0;
        end else begin
            g = 0; r = 0; mn = 0;
            if (cmd_lock) begin
                if (lock_aligned) begin g = 1; m_lock = 1; end
                else r = 1;
            end else if (wr_req) begin
                if (!m_mode) begin mn = 1; g = 1; end
                else begin
                    off = int'(addr[5:0]);
                    if (off < 16 || m_lock) r = 1;
                    else begin m_mem[off] = m_mem[off] & int'(wdata); g = 1; end
                end
            end else if (rd_start || rd_next) begin
                g = 1;
                if (!m_mode) mn = 1;
                else begin
                    off = rd_start ? int'(addr[5:0]) : m_ptr;
                    m_rdata = m_mem[off];
                    m_ptr = (off + 1) % 64;
                end
            end
            if (cmd_exit) m_mode = 0;
            else if (cmd_enter) m_mode = 1;
            m_grant = g; m_reject = r; m_main = mn;
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(otp_mode === m_mode, "R1", "otp_mode", int'(otp_mode), int'(m_mode));
            chk(main_go === m_main, "R2", "main_go", int'(main_go), int'(m_main));
            chk(grant === m_grant, "R10", "grant", int'(grant), int'(m_grant));
            chk(reject === m_reject, "R10", "reject", int'(reject), int'(m_reject));
            chk(rdata === 8'(m_rdata), cur_req, "rdata", int'(rdata), m_rdata);
            chk(secreg[1] === m_lock, "R6", "lock bit", int'(secreg[1]), int'(m_lock));
            chk({secreg[7:2], secreg[0]} === 7'b0000001, "R9", "secreg fixed bits",
                int'(secreg), 1);
        end
    end

    task automatic t_idle(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic t_enter();
        cmd_enter = 1; @(negedge clk); cmd_enter = 0;
    endtask
    task automatic t_exit();
        cmd_exit = 1; @(negedge clk); cmd_exit = 0;
    endtask
    task automatic t_lock(input bit aligned);
        cmd_lock = 1; lock_aligned = aligned; @(negedge clk);
        cmd_lock = 0; lock_aligned = 0;
    endtask
    task automatic t_wr(input int a, input int d);
        wr_req = 1; addr = ADDR_W'(a); wdata = 8'(d); @(negedge clk); wr_req = 0;
    endtask
    task automatic t_rs(input int a);
        rd_start = 1; addr = ADDR_W'(a); @(negedge clk); rd_start = 0;
    endtask
    task automatic t_rn(input int n);
        rd_next = 1; repeat (n) @(negedge clk); rd_next = 0;
    endtask

    // Watchdog: a hang counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        cmp_on = 1;                 // reset state compared here
        rst_n = 1;
        t_idle(2);

        // R2: outside OTP mode accesses go to the main array
        cur_req = "R2";
        t_wr(20, 8'h00); t_rs(16); t_rn(2); t_idle(2);

        // R1: enter, then R4 factory bytes streamed
        t_enter(); t_idle(1);
        cur_req = "R4";
        t_rs(0); t_rn(16); t_idle(1);
        t_wr(5, 8'h00); t_rs(5); t_idle(1);

        // R5: customer programming clears bits only
        cur_req = "R5";
        t_rs(20); t_wr(20, 8'hA5); t_rs(20); t_wr(20, 8'h0F); t_rs(20);
        t_wr(63, 8'h3C); t_rs(63); t_idle(1);

        // R3: offset from low bits, stream wrap past the end
        cur_req = "R3";
        t_rs(62); t_rn(3); t_rs(24'h123456); t_rn(1); t_idle(1);

        // R6: misaligned lock refused, aligned lock accepted
        cur_req = "R6";
        t_lock(0); t_idle(1); t_lock(1); t_idle(1);

        // R7: locked customer region refuses programs
        cur_req = "R7";
        t_wr(30, 8'h00); t_rs(30); t_wr(20, 8'h00); t_rs(20); t_lock(1); t_idle(1);

        // R1: exit wins over enter in the same cycle
        cmd_enter = 1; cmd_exit = 1; @(negedge clk); cmd_enter = 0; cmd_exit = 0;
        t_idle(1);
        cur_req = "R2";
        t_rs(30); t_idle(1);

        // R8: reset keeps the lock and the programmed bytes
        cur_req = "R8";
        t_enter(); t_rs(63);
        rst_n = 0; t_idle(2); rst_n = 1; t_idle(1);
        t_enter(); t_rs(20); t_rn(1); t_rs(63); t_wr(40, 8'h00); t_rs(40); t_exit();
        t_idle(3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule